// File: doc/BRIEF.md
# Dual-Line Edge-Triggered Interrupt Bank

This block gathers up to `NSRC` interrupt source inputs and reports them on two independent host interrupt outputs, each active low. Every source first passes through a two-flop synchronizer. A per-source pair of trigger bits then decides whether a rising edge, a falling edge, both or neither raise an event. One copy of the trigger settings serves both host lines. Each line keeps its own status and its own mask, so two hosts can each own a subset of the sources.

Software reaches the registers over a simple byte-wide bus. A read or write takes place in every clock cycle in which `bus_sel` is high, and read data is combinational. A control register chooses one of two clear methods for status: cleared by reading, or cleared by writing ones. The same register decides whether a second event that arrives on an already-flagged source is held back for later or dropped. A set register for each line lets test code force status bits. For each line a summary bit equal to "any unmasked status bit set" is brought out so that a higher-level aggregator can use it.

Top module: `irq_edge_bank`

## Requirements
- R1: After reset every mask bit reads 1, every status bit and every trigger bit reads 0, the control register reads 0x00, both `irqN_n` outputs are high and `line_sum` is 0.
- R2: A source whose rising-enable bit is 1 sets its status bit on both lines within four clock cycles of a 0-to-1 change on its input. A 1-to-0 change does not set it unless the falling-enable bit is also 1.
- R3: A source whose falling-enable bit is 1 sets its status bit on a 1-to-0 input change. With both enable bits set, either direction sets it.
- R4: A source whose two trigger bits are both 0 never sets its status bit, whatever its input does.
- R5: The trigger registers start at byte address 0x20 and hold ceil(2*NSRC/8) bytes. Source i uses byte 0x20+i/4: bit 2*(i mod 4)+1 enables rising edges and bit 2*(i mod 4) enables falling edges. One copy serves both lines.
- R6: `irq1_n` is low exactly when line 1 has a set status bit whose mask bit is 0, and `line_sum[0]` is the same condition with the polarity inverted. The same holds for `irq2_n` and `line_sum[1]` on line 2. The line 1 mask is at 0x08 and the line 2 mask is at 0x10, byte j at base+j, and a mask bit of 1 blocks its source.
- R7: Line 1 status is at 0x04 and line 2 status is at 0x0C, with byte j at base+j and source i at bit i mod 8 of byte i/8. Clearing status on one line leaves the other line's status unchanged.
- R8: With control bit 0 equal to 0, reading status does not change it. Writing a 1 to a status bit clears it, and writing a 0 leaves it as it is.
- R9: With control bit 0 equal to 1, reading a status byte clears the bits it returned, and writes to status registers have no effect.
- R10: With control bit 1 equal to 0, an event that arrives while its status bit is already set is held. That status bit is set again at once when it is cleared, so the next read returns it again. With control bit 1 equal to 1, such an event is discarded.
- R11: Writing ones to the set register of line 1 (0x14) or line 2 (0x18) forces the matching status bits of that line only, whatever the trigger settings. The set registers read as 0.
- R12: The control register at 0x00 reads back bit 0 (clear-by-read) and bit 1 (discard second event). All its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | NSRC | Interrupt source inputs, asynchronous |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq1_n | output | 1 | Host line 1 interrupt, active low |
| irq2_n | output | 1 | Host line 2 interrupt, active low |
| line_sum | output | 2 | Per-line summary for an aggregator, active high |

## Verification
Edge detection is driven with a single rising step, a single falling step, a source with both edges enabled and a source with no edge enabled. These cases show apart the role of each trigger bit and of their bit positions inside a packed byte. Clearing is tried in both modes: reads followed by writes of zeros and of ones in write-to-clear mode, and repeated reads plus ignored writes in clear-by-read mode. These show which access actually clears a bit and that the two lines stay separate. Two pulses in a row on one source, once with the second event held and once with it discarded, tell the buffering behaviour apart. The test-set register is used on sources whose trigger bits are off. The mask is opened on one line at a time to tie each output pin to its own line.

// File: rtl/irq_edge_bank.sv
`timescale 1ns/1ps
module irq_edge_bank #(
  parameter int NSRC = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [5:0]      bus_addr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  output logic            irq1_n,
  output logic            irq2_n,
  output logic [1:0]      line_sum
);

  localparam int NB = (NSRC + 7) / 8;
  localparam int NE = (2 * NSRC + 7) / 8;
  localparam int SW = 8 * NB;
  localparam int EW = 8 * NE;

  logic [NSRC-1:0]           sync1, sync2, prev, evt;
  logic [2*NSRC-1:0]         edg_q;
  logic [1:0][NSRC-1:0]      st_q, mk_q, pd_q, st_d, mk_d, pd_d, clr, setf;
  logic [1:0][SW-1:0]        stp, mkp;
  logic [EW-1:0]             edgp, elane, ebits;
  logic [SW-1:0]             lane, wbits;
  logic                      cor_q, pdis_q;
  logic [3:0]                slot;

  wire rd   = bus_sel & ~bus_wr;
  wire wr   = bus_sel & bus_wr;
  wire ewin = wr & (bus_addr[5:3] == 3'b100);
  assign slot = bus_addr[5:2];

  always_comb begin
    lane  = '0;
    elane = '0;
    for (int j = 0; j < NB; j++)
      if (bus_addr[1:0] == 2'(j)) lane[8*j +: 8] = 8'hFF;
    for (int j = 0; j < NE; j++)
      if (bus_addr[2:0] == 3'(j)) elane[8*j +: 8] = 8'hFF;
    wbits = lane & {NB{bus_wdata}};
    ebits = elane & {NE{bus_wdata}};
  end

  genvar i;
  for (i = 0; i < NSRC; i++) begin : g_evt
    assign evt[i] = (edg_q[2*i+1] & sync2[i] & ~prev[i]) |
                    (edg_q[2*i]   & ~sync2[i] & prev[i]);
  end

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      clr[k]  = '0;
      setf[k] = '0;
      mk_d[k] = mk_q[k];
      if (cor_q && rd && slot == 4'(1 + 2*k))
        clr[k] = lane[NSRC-1:0];
      if (!cor_q && wr && slot == 4'(1 + 2*k))
        clr[k] = wbits[NSRC-1:0];
      if (wr && slot == 4'(5 + k))
        setf[k] = wbits[NSRC-1:0];
      if (wr && slot == 4'(2 + 2*k))
        mk_d[k] = (mk_q[k] & ~lane[NSRC-1:0]) | wbits[NSRC-1:0];
      st_d[k] = (st_q[k] & ~clr[k]) | evt | setf[k] | (pd_q[k] & clr[k]);
      pd_d[k] = (pd_q[k] & ~clr[k]) |
                (evt & st_q[k] & ~clr[k] & {NSRC{~pdis_q}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      prev   <= '0;
      edg_q  <= '0;
      st_q   <= '0;
      mk_q   <= '1;
      pd_q   <= '0;
      cor_q  <= 1'b0;
      pdis_q <= 1'b0;
    end else begin
      sync1 <= src_in;
      sync2 <= sync1;
      prev  <= sync2;
      st_q  <= st_d;
      mk_q  <= mk_d;
      pd_q  <= pd_d;
      if (ewin)
        edg_q <= (edg_q & ~elane[2*NSRC-1:0]) | ebits[2*NSRC-1:0];
      if (wr && bus_addr == 6'h00) begin
        cor_q  <= bus_wdata[0];
        pdis_q <= bus_wdata[1];
      end
    end
  end

  always_comb begin
    stp  = '0;
    mkp  = '0;
    edgp = '0;
    for (int k = 0; k < 2; k++) begin
      stp[k][NSRC-1:0] = st_q[k];
      mkp[k][NSRC-1:0] = mk_q[k];
    end
    edgp[2*NSRC-1:0] = edg_q;
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (slot == 4'd0 && bus_addr[1:0] == 2'd0)
      bus_rdata = {6'b0, pdis_q, cor_q};
    for (int k = 0; k < 2; k++)
      for (int j = 0; j < NB; j++)
        if (bus_addr[1:0] == 2'(j)) begin
          if (slot == 4'(1 + 2*k)) bus_rdata = stp[k][8*j +: 8];
          if (slot == 4'(2 + 2*k)) bus_rdata = mkp[k][8*j +: 8];
        end
    for (int j = 0; j < NE; j++)
      if (bus_addr[5:3] == 3'b100 && bus_addr[2:0] == 3'(j))
        bus_rdata = edgp[8*j +: 8];
  end

  assign line_sum[0] = |(st_q[0] & ~mk_q[0]);
  assign line_sum[1] = |(st_q[1] & ~mk_q[1]);
  assign irq1_n = ~line_sum[0];
  assign irq2_n = ~line_sum[1];

endmodule

// File: rtl/irq_edge_bank_chk.sv
`timescale 1ns/1ps
module irq_edge_bank_chk #(
  parameter int NSRC = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic              cor,
  input logic [2*NSRC-1:0] edg,
  input logic [NSRC-1:0]   st1,
  input logic [NSRC-1:0]   st2,
  input logic [NSRC-1:0]   mk1,
  input logic [NSRC-1:0]   mk2,
  input logic              irq1_n,
  input logic              irq2_n
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (irq1_n && irq2_n && st1 == '0 && st2 == '0));

  // R4
  no_trigger_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edg == '0 && !(bus_sel && bus_wr)) |=>
      ((st1 & ~$past(st1)) == '0 && (st2 & ~$past(st2)) == '0));

  // R8
  w1c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cor && !(bus_sel && bus_wr)) |=>
      (($past(st1) & ~st1) == '0 && ($past(st2) & ~st2) == '0));

  // R6
  line1_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mk1) |-> irq1_n);

  // R6
  line2_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mk2) |-> irq2_n);

endmodule

bind irq_edge_bank irq_edge_bank_chk #(.NSRC(NSRC)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .bus_sel(bus_sel),
  .bus_wr (bus_wr),
  .cor    (cor_q),
  .edg    (edg_q),
  .st1    (st_q[0]),
  .st2    (st_q[1]),
  .mk1    (mk_q[0]),
  .mk2    (mk_q[1]),
  .irq1_n (irq1_n),
  .irq2_n (irq2_n)
);

// File: tb/irq_edge_bank_test.sv
`timescale 1ns/1ps
module irq_edge_bank_test;
  localparam int NSRC = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src_in = '0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, chk = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq1_n, irq2_n;
  logic [1:0] line_sum;

  typedef struct { bit pin; logic [7:0] exp; string tag; } item_t;
  item_t q[$];
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  irq_edge_bank #(.NSRC(NSRC)) uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq1_n(irq1_n), .irq2_n(irq2_n), .line_sum(line_sum));

  task automatic push(bit pin, logic [7:0] e, string t);
    item_t it;
    it.pin = pin; it.exp = e; it.tag = t;
    q.push_back(it);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk); #1;
      bus_sel = 1'b0; chk = 1'b0;
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk); #1;
    chk = 1'b0; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(logic [5:0] a, logic [7:0] e, string t);
    @(negedge clk); #1;
    chk = 1'b0; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    push(1'b0, e, t);
  endtask

  task automatic pins(logic [3:0] e, string t);
    @(negedge clk); #1;
    bus_sel = 1'b0; chk = 1'b1;
    push(1'b1, {4'b0, e}, t);
  endtask

  task automatic drive_src(logic [NSRC-1:0] v);
    @(negedge clk); #1;
    bus_sel = 1'b0; chk = 1'b0; src_in = v;
    idle(4);
  endtask

  initial begin : monitor
    item_t it;
    logic [7:0] act;
    forever begin
      @(negedge clk); #5;
      if ((bus_sel && !bus_wr) || chk) begin
        if (q.size() == 0) begin
          nchk++; nfail++;
          $display("FAIL scoreboard: no expectation, got %h expected none", bus_rdata);
        end else begin
          it = q.pop_front();
          act = it.pin ? {4'b0, line_sum, irq1_n, irq2_n} : bus_rdata;
          nchk++;
          if (act !== it.exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 200000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin : driver
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset values
    rd(6'h08, 8'hFF, "R1 mask1 byte0");
    rd(6'h0A, 8'hFF, "R1 mask1 byte2");
    rd(6'h12, 8'hFF, "R1 mask2 byte2");
    rd(6'h04, 8'h00, "R1 status1 byte0");
    rd(6'h20, 8'h00, "R1 trigger byte0");
    rd(6'h00, 8'h00, "R1 control");
    pins(4'b0011, "R1 outputs idle");
    // R4 no trigger bits: nothing sets
    drive_src('1);
    drive_src('0);
    rd(6'h04, 8'h00, "R4 status1 byte0");
    rd(6'h06, 8'h00, "R4 status1 byte2");
    rd(6'h0C, 8'h00, "R4 status2 byte0");
    // R5 trigger layout: src0 rise, src5 rise, src6 fall, src23 both
    wr(6'h20, 8'h02);
    wr(6'h21, 8'h18);
    wr(6'h25, 8'hC0);
    rd(6'h21, 8'h18, "R5 trigger byte1 readback");
    rd(6'h25, 8'hC0, "R5 trigger byte5 readback");
    wr(6'h08, 8'hFE);
    // R2 rising on src5 only
    drive_src(24'h000060);
    rd(6'h04, 8'h20, "R2 rise src5 line1");
    rd(6'h0C, 8'h20, "R5 shared trigger line2");
    pins(4'b0011, "R6 masked source no output");
    // R3 falling on src6 only
    drive_src(24'h000000);
    rd(6'h04, 8'h60, "R3 fall src6 line1");
    drive_src(24'h800000);
    rd(6'h06, 8'h80, "R3 both-edge rise src23");
    wr(6'h06, 8'h80);
    rd(6'h06, 8'h00, "R8 write one clears src23");
    rd(6'h0E, 8'h80, "R7 line2 unaffected");
    drive_src(24'h000000);
    rd(6'h06, 8'h80, "R3 both-edge fall src23");
    // R8 write-to-clear mode
    rd(6'h04, 8'h60, "R8 read no clear a");
    rd(6'h04, 8'h60, "R8 read no clear b");
    wr(6'h04, 8'h00);
    rd(6'h04, 8'h60, "R8 zero write no effect");
    wr(6'h04, 8'h20);
    rd(6'h04, 8'h40, "R8 one write clears bit5");
    rd(6'h0C, 8'h60, "R7 line2 keeps bit5");
    // R6 outputs
    drive_src(24'h000001);
    pins(4'b0101, "R6 line1 unmasked");
    wr(6'h08, 8'hFF);
    pins(4'b0011, "R6 line1 all masked");
    wr(6'h10, 8'hFE);
    pins(4'b1010, "R6 line2 unmasked");
    wr(6'h10, 8'hFF);
    // R9 clear-by-read
    wr(6'h00, 8'h01);
    rd(6'h00, 8'h01, "R12 control readback");
    rd(6'h04, 8'h41, "R9 first read");
    rd(6'h04, 8'h00, "R9 read cleared");
    wr(6'h0C, 8'hFF);
    rd(6'h0C, 8'h61, "R9 write ignored");
    rd(6'h0C, 8'h00, "R9 line2 cleared by read");
    // R10 held second event
    drive_src(24'h000000);
    drive_src(24'h000001);
    drive_src(24'h000000);
    drive_src(24'h000001);
    rd(6'h04, 8'h01, "R10 first read");
    rd(6'h04, 8'h01, "R10 held event reappears");
    rd(6'h04, 8'h00, "R10 held event consumed");
    wr(6'h00, 8'h03);
    rd(6'h00, 8'h03, "R12 control both bits");
    drive_src(24'h000000);
    drive_src(24'h000001);
    drive_src(24'h000000);
    drive_src(24'h000001);
    rd(6'h04, 8'h01, "R10 discard first read");
    rd(6'h04, 8'h00, "R10 second event discarded");
    // R11 test set
    wr(6'h15, 8'h03);
    rd(6'h05, 8'h03, "R11 forced line1");
    rd(6'h0D, 8'h00, "R11 line2 untouched");
    rd(6'h14, 8'h00, "R11 set reg reads zero");
    idle(3);
    if (q.size() != 0) begin
      nchk++; nfail++;
      $display("FAIL scoreboard: got %0d pending expected 0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule